// File: doc/BRIEF.md
# Dual I/O Fast-Read Byte Reassembler

This block watches the serial bus of a flash-style memory for a dual-I/O fast-read transaction and turns its serial traffic back into bytes. The four bus signals are chip select (active low), the serial clock and the two data lines. All four are sampled by the system clock and are assumed to be synchronous to it already. Each rising serial-clock edge seen while chip select is low is one shift event.

A transaction starts with an 8-bit command shifted in one bit per edge on data line 0. If the command equals the configured code, every later phase moves two bits per edge: a 24-bit address with its most significant byte first, one dummy byte, and then data bytes until chip select rises. Bytes are delimited only by counting bit pairs. The block presents the address, a pulse for the dummy byte, each data byte with a one-cycle strobe, a running count of data bytes, a pulse that marks the end of a data phase, and a flag for a byte left unfinished when chip select rises.

The controller has five states. `ST_CMD` collects the command bits and is also the reset and idle state. `ST_ADDR` collects the address bytes. `ST_DUMMY` consumes the dummy byte. `ST_DATA` delivers data bytes. `ST_SKIP` absorbs a transaction whose command did not match. The transitions are as follows:
- `ST_CMD` goes to `ST_ADDR` when a matching command completes, and to `ST_SKIP` when a command that does not match completes.
- `ST_ADDR` goes to `ST_DUMMY` when its last address byte completes.
- `ST_DUMMY` goes to `ST_DATA` when the dummy byte completes.
- Every state returns to `ST_CMD` whenever chip select is high.

Top module: `dio_dual_read`

## Requirements
- R1: While reset is asserted and right after it is released, every strobe (`addr_vld_o`, `dummy_o`, `data_vld_o`, `done_o`, `frag_o`) is low, and `addr_o`, `data_o` and `byte_cnt_o` are zero.
- R2: The command is taken on `sio0_i` only, one bit per rising `sck_i` edge, bit 7 first. Only the code `CMD_CODE` (default 0xBB) starts the two-line sequence. After any other code, no address, dummy or data strobe is raised until chip select goes high.
- R3: In every phase after the command, each rising edge adds two bits to the current byte. `sio1_i` holds the odd (higher) bit position and `sio0_i` the even one. The first edge of a byte carries bits 7 and 6, and four edges complete a byte.
- R4: The address is three bytes, most significant first. On the cycle after the clock edge that samples the twelfth two-line edge, `addr_vld_o` is high for exactly one cycle and `addr_o` holds the full 24-bit address. `addr_o` keeps that value until the next address is assembled.
- R5: The four edges after the address form the dummy byte. Its completion raises `dummy_o` for one cycle, and its value never appears on `data_o`.
- R6: Each completed data byte appears on `data_o` together with a one-cycle `data_vld_o` pulse. In that same cycle `byte_cnt_o` increases by one. `byte_cnt_o` is cleared when a matching command is accepted.
- R7: When chip select rises during the data phase, `done_o` pulses for one cycle and `byte_cnt_o` keeps the final count. The count is zero if chip select rose right after the dummy byte.
- R8: When chip select rises while a byte is only partly shifted, in any phase, `frag_o` pulses for one cycle and the partial bits are dropped without a data strobe.
- R9: Chip select high at any point returns the block to the command phase. The next transaction starts with a single-line command and decodes correctly even after an abort in the middle of the address.
- R10: Rising `sck_i` edges while chip select is high have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, sampled; its rising edges shift data |
| sio0_i | input | 1 | Data line 0: command bits, then even bit positions |
| sio1_i | input | 1 | Data line 1: odd bit positions |
| addr_o | output | 24 | Assembled address |
| addr_vld_o | output | 1 | One-cycle pulse when the address is complete |
| dummy_o | output | 1 | One-cycle pulse when the dummy byte is complete |
| data_o | output | 8 | Last reassembled data byte |
| data_vld_o | output | 1 | One-cycle strobe for `data_o` |
| byte_cnt_o | output | 16 | Data bytes delivered in the current transaction |
| done_o | output | 1 | One-cycle pulse when chip select ends a data phase |
| frag_o | output | 1 | One-cycle pulse when chip select drops a partial byte |

## Verification
Every result is registered once. A strobe caused by a serial-clock edge is high in the system-clock cycle that follows the first clock edge sampling `sck_i` high, and `done_o` and `frag_o` follow one cycle after the first edge that samples chip select high. The bench changes the bus only on falling system-clock edges. Its reference model advances at each rising edge from those same sampled inputs, and it compares every output a short delay after that edge, so the comparison never races with the design's own update. In addition, a queue of the bytes the stimulus meant to send is checked against each data strobe, and counters of strobes settle the cases where nothing should appear.

// File: rtl/dio_rd_pkg.sv
package dio_rd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_SKIP
    } dio_state_e;
endpackage

// File: rtl/dio_sck_rise.sv
module dio_sck_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic rise_o
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_i;
    end

    assign rise_o = sck_i & ~sck_q;
endmodule

// File: rtl/dio_pair_shift.sv
module dio_pair_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic              dual_i,
    input  logic              sio0_i,
    input  logic              sio1_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_done_o,
    output logic              partial_o
);
    localparam int POS_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_q, sh_nxt;
    logic [POS_W-1:0]  pos_q, pos_nxt, inc;

    // The bit position wraps to zero exactly when a byte completes.
    always_comb begin
        inc     = dual_i ? POS_W'(2) : POS_W'(1);
        sh_nxt  = dual_i ? {sh_q[BYTE_W-3:0], sio1_i, sio0_i}
                         : {sh_q[BYTE_W-2:0], sio0_i};
        pos_nxt = pos_q + inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            pos_q <= '0;
        end else if (clr_i) begin
            sh_q  <= '0;
            pos_q <= '0;
        end else if (step_i) begin
            sh_q  <= sh_nxt;
            pos_q <= pos_nxt;
        end
    end

    assign byte_o      = sh_nxt;
    assign byte_done_o = step_i && (pos_nxt == '0);
    assign partial_o   = (pos_q != '0);
endmodule

// File: rtl/dio_dual_read.sv
module dio_dual_read
    import dio_rd_pkg::*;
#(
    parameter logic [7:0] CMD_CODE   = 8'hBB,
    parameter int         ADDR_BYTES = 3,
    parameter int         CNT_W      = 16,
    localparam int        ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              sio0_i,
    input  logic              sio1_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o,
    output logic              dummy_o,
    output logic [7:0]        data_o,
    output logic              data_vld_o,
    output logic [CNT_W-1:0]  byte_cnt_o,
    output logic              done_o,
    output logic              frag_o
);
    localparam int AB_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    dio_state_e        state_q, state_d;
    logic              sck_rise, step, dual;
    logic [BYTE_W-1:0] cur_byte;
    logic              byte_done, partial;
    logic [AB_W-1:0]   abyte_q;
    logic              last_abyte;

    dio_sck_rise u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_i),
        .rise_o (sck_rise)
    );

    assign step       = sck_rise && !cs_n_i && (state_q != ST_SKIP);
    assign dual       = (state_q == ST_ADDR) || (state_q == ST_DUMMY)
                     || (state_q == ST_DATA);
    assign last_abyte = (abyte_q == AB_W'(ADDR_BYTES - 1));

    dio_pair_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (cs_n_i),
        .step_i      (step),
        .dual_i      (dual),
        .sio0_i      (sio0_i),
        .sio1_i      (sio1_i),
        .byte_o      (cur_byte),
        .byte_done_o (byte_done),
        .partial_o   (partial)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n_i) begin
            state_d = ST_CMD;
        end else begin
            unique case (state_q)
                ST_CMD:   if (byte_done)
                              state_d = (cur_byte == CMD_CODE) ? ST_ADDR : ST_SKIP;
                ST_ADDR:  if (byte_done && last_abyte) state_d = ST_DUMMY;
                ST_DUMMY: if (byte_done) state_d = ST_DATA;
                ST_DATA:  state_d = ST_DATA;
                ST_SKIP:  state_d = ST_SKIP;
                default:  state_d = ST_CMD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    // Address byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            abyte_q <= '0;
        else if (cs_n_i || state_q == ST_CMD)
            abyte_q <= '0;
        else if (state_q == ST_ADDR && byte_done)
            abyte_q <= abyte_q + AB_W'(1);
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o     <= '0;
            addr_vld_o <= 1'b0;
            dummy_o    <= 1'b0;
            data_o     <= '0;
            data_vld_o <= 1'b0;
            byte_cnt_o <= '0;
            done_o     <= 1'b0;
            frag_o     <= 1'b0;
        end else begin
            addr_vld_o <= 1'b0;
            dummy_o    <= 1'b0;
            data_vld_o <= 1'b0;
            done_o     <= 1'b0;
            frag_o     <= 1'b0;
            if (cs_n_i) begin
                done_o <= (state_q == ST_DATA);
                frag_o <= partial;
            end else if (byte_done) begin
                unique case (state_q)
                    ST_CMD: begin
                        if (cur_byte == CMD_CODE) byte_cnt_o <= '0;
                    end
                    ST_ADDR: begin
                        addr_o <= ADDR_W'({addr_o, cur_byte});
                        if (last_abyte) addr_vld_o <= 1'b1;
                    end
                    ST_DUMMY: dummy_o <= 1'b1;
                    ST_DATA: begin
                        data_o     <= cur_byte;
                        data_vld_o <= 1'b1;
                        byte_cnt_o <= byte_cnt_o + CNT_W'(1);
                    end
                    ST_SKIP: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dio_rd_chk.sv
module dio_rd_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_i,
    input logic             addr_vld_o,
    input logic             dummy_o,
    input logic             data_vld_o,
    input logic [CNT_W-1:0] byte_cnt_o,
    input logic             done_o,
    input logic             frag_o
);
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_vld_o, dummy_o, data_vld_o}));

    assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld_o |=> !data_vld_o);

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld_o |-> (byte_cnt_o - $past(byte_cnt_o)) == CNT_W'(1));

    assert_data_cs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld_o |-> !$past(cs_n_i));

    assert_done_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cs_n_i) && $stable(byte_cnt_o)));

    assert_frag_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frag_o |-> $past(cs_n_i));

    assert_quiet_cs_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_i) |-> !(addr_vld_o || dummy_o || data_vld_o));
endmodule

bind dio_dual_read dio_rd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .addr_vld_o (addr_vld_o),
    .dummy_o    (dummy_o),
    .data_vld_o (data_vld_o),
    .byte_cnt_o (byte_cnt_o),
    .done_o     (done_o),
    .frag_o     (frag_o)
);

// File: tb/dio_dual_read_tb_top.sv
module dio_dual_read_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sio0 = 1'b0, sio1 = 1'b0;
    logic [23:0] addr_o;
    logic [7:0]  data_o;
    logic [15:0] byte_cnt_o;
    logic addr_vld_o, dummy_o, data_vld_o, done_o, frag_o;

    int n_tests = 0, n_fail = 0;
    int n_vld = 0, n_addr = 0, n_dummy = 0, n_done = 0, n_frag = 0, cyc = 0;
    bit [7:0] want_q[$];

    // behavioural reference state
    int m_phase = 0, m_nbits = 0, m_acc = 0, m_ab = 0, m_prev = 0;
    logic [23:0] e_addr = 0;
    logic [7:0]  e_data = 0;
    int e_cnt = 0;
    bit e_av, e_dm, e_dv, e_dn, e_fr;

    always #5 clk = ~clk;

    dio_dual_read dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck),
        .sio0_i(sio0), .sio1_i(sio1), .addr_o(addr_o), .addr_vld_o(addr_vld_o),
        .dummy_o(dummy_o), .data_o(data_o), .data_vld_o(data_vld_o),
        .byte_cnt_o(byte_cnt_o), .done_o(done_o), .frag_o(frag_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // model update at each rising edge, comparison shortly after
    always @(posedge clk) begin
        int b;
        bit rise;
        cyc++;
        {e_av, e_dm, e_dv, e_dn, e_fr} = '0;
        if (!rst_n) begin
            m_phase = 0; m_nbits = 0; m_acc = 0; m_ab = 0; m_prev = 0;
            e_addr = 0; e_data = 0; e_cnt = 0;
        end else begin
            rise = sck && (m_prev == 0);
            m_prev = sck;
            if (cs_n) begin
                e_dn = (m_phase == 3);
                e_fr = (m_nbits != 0);
                m_phase = 0; m_nbits = 0; m_acc = 0; m_ab = 0;
            end else if (rise && m_phase != 4) begin
                if (m_phase == 0) begin
                    m_acc = (m_acc << 1) | sio0;
                    m_nbits++;
                    if (m_nbits == 8) begin
                        if ((m_acc & 255) == 8'hBB) begin m_phase = 1; e_cnt = 0; m_ab = 0; end
                        else m_phase = 4;
                        m_nbits = 0; m_acc = 0;
                    end
                end else begin
                    m_acc = (m_acc << 2) | (sio1 << 1) | sio0;
                    m_nbits += 2;
                    if (m_nbits == 8) begin
                        b = m_acc & 255;
                        m_nbits = 0; m_acc = 0;
                        if (m_phase == 1) begin
                            e_addr = {e_addr[15:0], b[7:0]};
                            m_ab++;
                            if (m_ab == 3) begin e_av = 1; m_phase = 2; end
                        end else if (m_phase == 2) begin
                            e_dm = 1; m_phase = 3;
                        end else begin
                            e_data = b[7:0]; e_dv = 1; e_cnt++;
                        end
                    end
                end
            end
        end
        #2;
        chk(rst_n ? "R4" : "R1", "addr_o", int'(addr_o), int'(e_addr));
        chk(rst_n ? "R4" : "R1", "addr_vld_o", int'(addr_vld_o), int'(e_av));
        chk(rst_n ? "R5" : "R1", "dummy_o", int'(dummy_o), int'(e_dm));
        chk(rst_n ? "R6" : "R1", "data_vld_o", int'(data_vld_o), int'(e_dv));
        chk(rst_n ? "R3" : "R1", "data_o", int'(data_o), int'(e_data));
        chk(rst_n ? "R6" : "R1", "byte_cnt_o", int'(byte_cnt_o), e_cnt);
        chk(rst_n ? "R7" : "R1", "done_o", int'(done_o), int'(e_dn));
        chk(rst_n ? "R8" : "R1", "frag_o", int'(frag_o), int'(e_fr));
        if (data_vld_o) begin
            n_vld++;
            if (want_q.size() == 0) chk("R5", "unexpected data byte", int'(data_o), -1);
            else chk("R3", "data byte vs stimulus", int'(data_o), int'(want_q.pop_front()));
        end
        if (addr_vld_o) n_addr++;
        if (dummy_o)    n_dummy++;
        if (done_o)     n_done++;
        if (frag_o)     n_frag++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // one serial edge pair: low for two cycles, then high for two
    task automatic pulse(bit b1, bit b0);
        sio1 = b1; sio0 = b0; sck = 1'b0;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_single(bit [7:0] v);
        for (int i = 7; i >= 0; i--) pulse(1'b0, v[i]);
    endtask

    task automatic send_dual(bit [7:0] v);
        for (int k = 3; k >= 0; k--) pulse(v[2*k+1], v[2*k]);
    endtask

    task automatic cs_low();
        cs_n = 1'b0; repeat (2) @(negedge clk);
    endtask

    task automatic cs_high();
        sck = 1'b0; cs_n = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic header(bit [23:0] a, bit [7:0] dmy);
        send_single(8'hBB);
        send_dual(a[23:16]); send_dual(a[15:8]); send_dual(a[7:0]);
        send_dual(dmy);
    endtask

    initial begin
        int v0, a0, f0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "byte_cnt after reset", int'(byte_cnt_o), 0);

        // main read with three data bytes
        v0 = n_vld;
        cs_low(); header(24'h123456, 8'hA5);
        want_q.push_back(8'h3C); send_dual(8'h3C);
        want_q.push_back(8'hC3); send_dual(8'hC3);
        want_q.push_back(8'h96); send_dual(8'h96);
        cs_high();
        chk("R6", "data strobes in read", n_vld - v0, 3);
        chk("R7", "final byte count", int'(byte_cnt_o), 3);
        chk("R4", "address held", int'(addr_o), 24'h123456);

        // non-matching command
        v0 = n_vld; a0 = n_addr;
        cs_low(); send_single(8'h3B);
        for (int i = 0; i < 5; i++) send_dual(8'h77);
        cs_high();
        chk("R2", "data strobes after wrong command", n_vld - v0, 0);
        chk("R2", "address strobes after wrong command", n_addr - a0, 0);

        // abort inside the address, then a clean transaction
        f0 = n_frag; v0 = n_vld;
        cs_low(); send_single(8'hBB); send_dual(8'hFF);
        pulse(1'b1, 1'b0);
        cs_high();
        chk("R8", "fragment flag on address abort", n_frag - f0, 1);
        cs_low(); header(24'hABCDEF, 8'h00);
        want_q.push_back(8'h5A); send_dual(8'h5A);
        cs_high();
        chk("R9", "address after restart", int'(addr_o), 24'hABCDEF);
        chk("R9", "data after restart", n_vld - v0, 1);

        // partial data byte
        f0 = n_frag; v0 = n_vld;
        cs_low(); header(24'h000001, 8'hFF);
        want_q.push_back(8'h81); send_dual(8'h81);
        pulse(1'b1, 1'b1); pulse(1'b0, 1'b1);
        cs_high();
        chk("R8", "fragment flag on partial data", n_frag - f0, 1);
        chk("R8", "partial byte not delivered", n_vld - v0, 1);

        // serial edges with chip select high
        v0 = n_vld; a0 = n_addr; d0 = n_dummy;
        for (int i = 0; i < 40; i++) pulse(i[0], i[1]);
        sck = 1'b0; repeat (2) @(negedge clk);
        chk("R10", "data strobes with cs high", n_vld - v0, 0);
        chk("R10", "address strobes with cs high", n_addr - a0, 0);
        chk("R10", "dummy strobes with cs high", n_dummy - d0, 0);

        // dummy then immediate end
        d0 = n_done;
        cs_low(); header(24'h00F00F, 8'h12);
        cs_high();
        chk("R7", "done after empty data phase", n_done - d0, 1);
        chk("R7", "zero byte count", int'(byte_cnt_o), 0);
        chk("R5", "dummy never delivered", want_q.size(), 0);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule